// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a small word-addressed memory in which every word carries one extra state bit telling whether the word currently holds an unconsumed value (full) or is free to be written (empty). A producer port writes words and a consumer port reads them. A write is accepted only into an empty word and marks it full. A read is accepted only from a full word and marks it empty. Every access through these two ports is therefore a blocking synchronization operation, and no path on them bypasses the tag check.

An access that cannot proceed sees its ready output low. The requester holds the request, and it is evaluated again on every cycle until the tag allows it. A separate setup port writes data and tag directly, whatever the tag's current state. It is meant for initialisation and not for normal traffic. Read data comes from a block-RAM style array and is presented one cycle after the read is accepted, qualified by a valid strobe.

Top module: `fe_sync_mem`

## Requirements
- R1: After a synchronous reset, every tag is empty. A consumer request to any word sees cons_ready low, and a producer request to any word sees prod_ready high.
- R2: A producer request is accepted (prod_ready high) only when the addressed tag is empty. On the clock edge of acceptance, the word takes prod_data and its tag becomes full.
- R3: A consumer request is accepted (cons_ready high) only when the addressed tag is full. On the clock edge of acceptance, the tag becomes empty.
- R4: A refused request changes neither data nor tag. Held unchanged, it is accepted in the first cycle in which the tag reaches the required state.
- R5: When both ports address the same word in one cycle, at most one is accepted. An empty tag lets the producer through and a full tag lets the consumer through, so a tag changes at most once per edge.
- R6: Requests to different words are independent, and both may be accepted in the same cycle.
- R7: While init_we is high, both ready outputs are low. On that edge the word at init_addr takes init_data and its tag takes init_full (1 = full, 0 = empty), regardless of its previous tag.
- R8: cons_valid is high in exactly the cycle after an accepted read and is low otherwise. In that cycle, cons_data holds the word's contents as they were before the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_req | input | 1 | Producer write request |
| prod_addr | input | ADDR_W | Producer word address |
| prod_data | input | DATA_W | Producer write data |
| prod_ready | output | 1 | Producer write accepted this cycle |
| cons_req | input | 1 | Consumer read request |
| cons_addr | input | ADDR_W | Consumer word address |
| cons_ready | output | 1 | Consumer read accepted this cycle |
| cons_data | output | DATA_W | Read data, registered |
| cons_valid | output | 1 | cons_data holds a completed read |
| init_we | input | 1 | Setup write strobe, overrides both ports |
| init_addr | input | ADDR_W | Setup word address |
| init_data | input | DATA_W | Setup data |
| init_full | input | 1 | Tag value written by the setup port |

## Verification
Several rules are checked by assertions on every cycle. A tag is only set when it was empty and only cleared when it was full. No tag is both set and cleared on one edge, and an untouched tag holds its value. Reset empties all tags, the setup strobe blocks both ports, and the valid strobe follows accepted reads alone. Other behaviour can only be shown by the bench scenarios, which compare against a reference model of the whole memory. These cover the returned data values, the order in which a stalled request finally wins, the same-word arbitration outcome for each tag state, and the full address-pair sweep.

// File: rtl/fe_pkg.sv
package fe_pkg;
  // Source feeding the single RAM write port
  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_PROD = 2'd1,
    WSRC_INIT = 2'd2
  } wsrc_e;
endpackage

// File: rtl/fe_access_ctl.sv
// Decides which accesses proceed this cycle from the current tag vector.
module fe_access_ctl #(
  parameter int ADDR_W = 3,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              init_we,
  input  logic              prod_req,
  input  logic [ADDR_W-1:0] prod_addr,
  input  logic              cons_req,
  input  logic [ADDR_W-1:0] cons_addr,
  input  logic [WORDS-1:0]  full_i,
  output logic              prod_go,
  output logic              cons_go,
  output logic [WORDS-1:0]  set_vec,
  output logic [WORDS-1:0]  clr_vec,
  output fe_pkg::wsrc_e     wsrc
);
  import fe_pkg::*;

  always_comb begin
    prod_go = prod_req && !init_we && !full_i[prod_addr];
    cons_go = cons_req && !init_we &&  full_i[cons_addr];
    if (init_we)      wsrc = WSRC_INIT;
    else if (prod_go) wsrc = WSRC_PROD;
    else              wsrc = WSRC_NONE;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_dec
    assign set_vec[i] = prod_go && (prod_addr == ADDR_W'(i));
    assign clr_vec[i] = cons_go && (cons_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/fe_tag_array.sv
// One full/empty flag per word, reset to empty.
module fe_tag_array #(
  parameter int ADDR_W = 3,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORDS-1:0]  set_vec,
  input  logic [WORDS-1:0]  clr_vec,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic              init_full,
  output logic [WORDS-1:0]  full_o
);
  logic [WORDS-1:0] full_q;
  logic [WORDS-1:0] init_hit;

  for (genvar i = 0; i < WORDS; i++) begin : g_hit
    assign init_hit[i] = init_we && (init_addr == ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (init_hit[i])     full_q[i] <= init_full;
        else if (set_vec[i]) full_q[i] <= 1'b1;
        else if (clr_vec[i]) full_q[i] <= 1'b0;
      end
    end
  end

  assign full_o = full_q;

  // R1: reset leaves every word empty
  a_r1_reset_empty: assert property (@(posedge clk) rst |=> (full_q == '0));

  for (genvar i = 0; i < WORDS; i++) begin : g_chk
    // R2: a word is only filled while it is empty
    a_r2_set_only_empty: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |-> !full_q[i]);
    // R3: a word is only drained while it is full
    a_r3_clr_only_full: assert property (@(posedge clk) disable iff (rst)
      clr_vec[i] |-> full_q[i]);
    // R5: a tag never sees two changes on one edge
    a_r5_single_change: assert property (@(posedge clk) disable iff (rst)
      !(set_vec[i] && clr_vec[i]));
    // R4: an untouched tag keeps its value
    a_r4_tag_holds: assert property (@(posedge clk) disable iff (rst)
      (!set_vec[i] && !clr_vec[i] && !init_hit[i]) |=> (full_q[i] == $past(full_q[i])));
  end
endmodule

// File: rtl/fe_data_ram.sv
// Simple dual-port RAM, one write port and one registered read port.
module fe_data_ram #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prod_req,
  input  logic [ADDR_W-1:0] prod_addr,
  input  logic [DATA_W-1:0] prod_data,
  output logic              prod_ready,
  input  logic              cons_req,
  input  logic [ADDR_W-1:0] cons_addr,
  output logic              cons_ready,
  output logic [DATA_W-1:0] cons_data,
  output logic              cons_valid,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [DATA_W-1:0] init_data,
  input  logic              init_full
);
  import fe_pkg::*;
  localparam int WORDS = 1 << ADDR_W;

  logic [WORDS-1:0]  full_w, set_w, clr_w;
  logic              prod_go, cons_go;
  wsrc_e             wsrc;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic              valid_q;

  fe_access_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .init_we  (init_we),
    .prod_req (prod_req),
    .prod_addr(prod_addr),
    .cons_req (cons_req),
    .cons_addr(cons_addr),
    .full_i   (full_w),
    .prod_go  (prod_go),
    .cons_go  (cons_go),
    .set_vec  (set_w),
    .clr_vec  (clr_w),
    .wsrc     (wsrc)
  );

  fe_tag_array #(.ADDR_W(ADDR_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_w),
    .clr_vec  (clr_w),
    .init_we  (init_we),
    .init_addr(init_addr),
    .init_full(init_full),
    .full_o   (full_w)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = prod_addr;
    ram_wdata = prod_data;
    case (wsrc)
      WSRC_INIT: begin
        ram_we    = 1'b1;
        ram_waddr = init_addr;
        ram_wdata = init_data;
      end
      WSRC_PROD: ram_we = 1'b1;
      default:   ram_we = 1'b0;
    endcase
  end

  fe_data_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (cons_go),
    .raddr(cons_addr),
    .rdata(cons_data)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= cons_go;
  end

  assign prod_ready = prod_go;
  assign cons_ready = cons_go;
  assign cons_valid = valid_q;

  // R7: setup writes block both synchronizing ports
  a_r7_init_blocks: assert property (@(posedge clk) disable iff (rst)
    init_we |-> (!prod_ready && !cons_ready));
  // R8: valid follows an accepted read by one cycle
  a_r8_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    (cons_req && cons_ready) |=> cons_valid);
  // R8: no valid without an accepted read
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(cons_req && cons_ready) |=> !cons_valid);
  // R5: same word, same cycle: never both accepted
  a_r5_one_winner: assert property (@(posedge clk) disable iff (rst)
    (prod_addr == cons_addr) |-> !(prod_ready && cons_ready));
endmodule

// File: tb/sim_fe_sync_mem.sv
module sim_fe_sync_mem;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prod_req = 1'b0, cons_req = 1'b0, init_we = 1'b0, init_full = 1'b0;
  logic [AW-1:0] prod_addr = '0, cons_addr = '0, init_addr = '0;
  logic [DW-1:0] prod_data = '0, init_data = '0;
  logic prod_ready, cons_ready, cons_valid;
  logic [DW-1:0] cons_data;

  int n_run = 0;
  int n_fail = 0;
  bit ef [NW];
  logic [DW-1:0] em [NW];

  always #2 clk = ~clk;

  fe_sync_mem #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .prod_req(prod_req), .prod_addr(prod_addr), .prod_data(prod_data), .prod_ready(prod_ready),
    .cons_req(cons_req), .cons_addr(cons_addr), .cons_ready(cons_ready),
    .cons_data(cons_data), .cons_valid(cons_valid),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data), .init_full(init_full)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check readies, update model, check read result.
  task automatic cyc(input string req, input bit pr, input int pa, input int pd,
                     input bit cr, input int ca,
                     input bit iw = 0, input int ia = 0, input int id = 0, input bit ifl = 0);
    bit ep, ec;
    int rd;
    prod_req = pr; prod_addr = AW'(pa); prod_data = DW'(pd);
    cons_req = cr; cons_addr = AW'(ca);
    init_we = iw; init_addr = AW'(ia); init_data = DW'(id); init_full = ifl;
    #1;
    ep = pr && !iw && !ef[pa];
    ec = cr && !iw && ef[ca];
    rd = int'(em[ca]);
    chk(prod_ready == ep, req, "prod_ready", int'(prod_ready), int'(ep));
    chk(cons_ready == ec, req, "cons_ready", int'(cons_ready), int'(ec));
    @(posedge clk);
    if (iw) begin
      ef[ia] = ifl; em[ia] = DW'(id);
    end else begin
      if (ep) begin ef[pa] = 1'b1; em[pa] = DW'(pd); end
      if (ec) ef[ca] = 1'b0;
    end
    @(negedge clk);
    // R8: valid strobe and data one cycle after acceptance
    chk(cons_valid == ec, "R8", "cons_valid", int'(cons_valid), int'(ec));
    if (ec) chk(int'(cons_data) == rd, req, "cons_data", int'(cons_data), rd);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin ef[i] = 0; em[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: all words empty after reset
    for (int w = 0; w < NW; w++) cyc("R1", 0, 0, 0, 1, w);
    // R2: fill every word
    for (int w = 0; w < NW; w++) cyc("R2", 1, w, w * 37 + 5, 0, 0);
    // R4: second write to a full word stalls, data untouched
    for (int w = 0; w < NW; w++) cyc("R4", 1, w, 8'hEE, 0, 0);
    // R3: drain every word, then reading again stalls
    for (int w = 0; w < NW; w++) cyc("R3", 0, 0, 0, 1, w);
    for (int w = 0; w < NW; w++) cyc("R3", 0, 0, 0, 1, w);
    // R5: same word, empty then full
    cyc("R5", 1, 2, 8'h3C, 1, 2);
    cyc("R5", 1, 2, 8'h77, 1, 2);
    // R6: different words both proceed
    cyc("R6", 1, 1, 8'h11, 0, 0);
    cyc("R6", 1, 6, 8'h66, 1, 1);
    cyc("R6", 0, 0, 0, 1, 6);
    // R4: consumer waits on empty word, producer then fills it
    for (int k = 0; k < 3; k++) cyc("R4", 0, 0, 0, 1, 3);
    cyc("R4", 1, 3, 8'h9A, 1, 3);
    cyc("R4", 0, 0, 0, 1, 3);
    // R7: setup port overrides tags and blocks both ports
    cyc("R7", 1, 4, 8'h01, 1, 4, 1, 4, 8'hA5, 1);
    cyc("R7", 1, 4, 8'h02, 0, 0);
    cyc("R7", 0, 0, 0, 1, 4);
    cyc("R7", 1, 5, 8'h55, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 1, 5, 8'h00, 0);
    cyc("R7", 0, 0, 0, 1, 5);
    // R5 and R6: sweep all address pairs with both ports active
    for (int pa = 0; pa < NW; pa++)
      for (int ca = 0; ca < NW; ca++)
        cyc((pa == ca) ? "R5" : "R6", 1, pa, pa * 16 + ca, 1, ca);
    // drain and confirm every word ends empty
    for (int w = 0; w < NW; w++) cyc("R3", 0, 0, 0, 1, w);
    for (int w = 0; w < NW; w++) cyc("R3", 0, 0, 0, 1, w);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule